// File: doc/BRIEF.md
# Host Command and Interrupt Status Register Block

This block is the host-facing control register set of a network controller. Through three memory-mapped registers the host reads the interrupt causes and the current states of the command unit and the receive unit. It acknowledges causes, posts commands to either unit, and loads a general 32-bit pointer that travels with each command. Event pulses from inside the controller set the cause bits. A single interrupt output is raised while any cause is set, unless the host has masked it.

A command written into the command register is held as pending and offered to its unit on a valid/ready port, together with the pointer value that was current when the command was written. The pending code stays visible in the command register until the unit takes it, and then reads back as zero. This lets the host poll for acceptance. Back-pressure rules on both unit ports: valid stays high and op and ptr stay unchanged for as long as ready is low. The transfer completes on the first rising edge with valid and ready both high. A unit may hold ready high at all times. The block never withdraws a request.

The register map is: address 0 status, address 1 command, address 2 pointer, address 3 reads zero. Writes are whole-register, single-cycle. Reads are combinational from `host_addr`, and the upper 16 bits read zero for the 16-bit registers.

Top module: `host_cmd_stat`

## Requirements
- R1: An event pulse on `ev_set` sets the status cause bits at positions 15, 14, 13, 12, 11, 10 and 8 on the next clock edge; `ev_set` bits 9 and 7:0 have no effect.
- R2: Writing the status register clears each cause bit written as 1 (write-one-to-clear); bits written as 0 and non-cause bits have no effect; an event arriving in the same cycle as its acknowledge leaves the bit set.
- R3: Writing the command register with bit 9 set raises cause bit 10 on the next edge; command bit 9 always reads 0.
- R4: `irq` is high exactly when some cause bit is set and mask bit 8 of the command register is 0; the mask resets to 1 and is loaded from bit 8 by every command write.
- R5: Status bits 7:6 show `cu_state` and status bits 5:2 show `ru_state` in the same cycle; status bits 1:0 and 9 read 0.
- R6: A command write with a nonzero value in bits 7:4, while no command-unit request is pending, raises `cu_valid` on the next edge with `cu_op` equal to that value and `cu_ptr` equal to the pointer register at the write.
- R7: Likewise bits 2:0 start a receive-unit request on `ru_valid`/`ru_op`/`ru_ptr`; a value of 0 in that field makes no request.
- R8: While a request is pending and its ready is low, valid stays high and op and ptr stay unchanged, and the pending code reads back in its command field.
- R9: After a valid-and-ready edge the unit's valid is low and its command field reads 0.
- R10: A command write to a field whose unit still has a request pending is ignored for that field only; the other unit's field and the mask are still taken.
- R11: The pointer register at address 2 reads back the last value written; after reset the status reads 0 (with unit states 0), the command reads 0x0100, the pointer reads 0, and neither valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 2 | Register address (0 status, 1 command, 2 pointer) |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data for `host_addr` |
| ev_set | input | 16 | Internal event pulses, one per cause bit position |
| cu_state | input | 2 | Current command-unit state |
| ru_state | input | 4 | Current receive-unit state |
| cu_valid | output | 1 | Command-unit request valid |
| cu_ready | input | 1 | Command unit accepts the request |
| cu_op | output | 4 | Command-unit command code |
| cu_ptr | output | 32 | Pointer captured with the command-unit command |
| ru_valid | output | 1 | Receive-unit request valid |
| ru_ready | input | 1 | Receive unit accepts the request |
| ru_op | output | 3 | Receive-unit command code |
| ru_ptr | output | 32 | Pointer captured with the receive-unit command |
| irq | output | 1 | Interrupt request |

## Verification
A wrong cause flop shows up on `irq` and in the status read one cycle after the event or acknowledge that touched it. A lost or doubled command shows on the unit port or in the command read-back in the cycle after the write or handshake. A pointer captured at the wrong time shows as a wrong `cu_ptr`/`ru_ptr` while the request is still waiting. The cases that matter most are an event colliding with its own acknowledge, a write that lands on a busy field next to an idle one, and a handshake on one unit while the other unit keeps waiting.

// File: rtl/hcs_pkg.sv
package hcs_pkg;
  localparam int HREG_W   = 16;
  localparam int PTR_W    = 32;
  localparam int CU_OP_W  = 4;
  localparam int RU_OP_W  = 3;
  localparam int CU_LSB   = 4;
  localparam int RU_LSB   = 0;
  localparam int MASK_BIT = 8;
  localparam int TRIG_BIT = 9;
  localparam int SWI_BIT  = 10;
  localparam int CUST_LSB = 6;
  localparam int RUST_LSB = 2;
  localparam logic [HREG_W-1:0] CAUSE_BITS = 16'hFD00;

  typedef enum logic [1:0] {
    A_STATUS = 2'd0,
    A_CMD    = 2'd1,
    A_PTR    = 2'd2,
    A_NONE   = 2'd3
  } haddr_e;
endpackage

// File: rtl/hcs_cause.sv
module hcs_cause
  import hcs_pkg::*;
#(
  parameter int W = HREG_W,
  parameter logic [W-1:0] KEEP = CAUSE_BITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         ack_wr,
  input  logic [W-1:0] ack_vec,
  input  logic         mask,
  output logic [W-1:0] cause,
  output logic         irq
);
  logic [W-1:0] clr_eff;
  logic [W-1:0] cause_q;

  assign clr_eff = ack_wr ? ack_vec : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= ((cause_q & ~clr_eff) | set_vec) & KEEP;
  end

  assign cause = cause_q;
  assign irq   = (|cause_q) & ~mask;

  // R1
  set_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec & KEEP) != '0) |=> ((cause & $past(set_vec & KEEP)) == $past(set_vec & KEEP)));
  // R2
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wr |=> ((cause & $past(ack_vec & ~set_vec)) == '0));
  // R4
  mask_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask |-> !irq);
endmodule

// File: rtl/hcs_cmd_slot.sv
module hcs_cmd_slot #(
  parameter int OP_W  = 4,
  parameter int PTR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [OP_W-1:0]  wop,
  input  logic [PTR_W-1:0] wptr,
  input  logic             ready,
  output logic             valid,
  output logic [OP_W-1:0]  op,
  output logic [PTR_W-1:0] ptr
);
  logic [OP_W-1:0]  op_q;
  logic [PTR_W-1:0] ptr_q;
  logic             busy;
  logic             take;
  logic             load;

  assign busy = (op_q != '0);
  assign take = busy && ready;
  assign load = !busy && wr && (wop != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= '0;
      ptr_q <= '0;
    end else if (take) begin
      op_q  <= '0;
    end else if (load) begin
      op_q  <= wop;
      ptr_q <= wptr;
    end
  end

  assign valid = busy;
  assign op    = op_q;
  assign ptr   = ptr_q;

  // R6 R7
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid && wr && wop != '0) |=> (valid && op == $past(wop) && ptr == $past(wptr)));
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(op) && $stable(ptr)));
  // R9
  accept_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready) |=> !valid);
  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && wr) |=> (op == $past(op)));
endmodule

// File: rtl/host_cmd_stat.sv
module host_cmd_stat
  import hcs_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_wr,
  input  logic [1:0]          host_addr,
  input  logic [PTR_W-1:0]    host_wdata,
  output logic [PTR_W-1:0]    host_rdata,
  input  logic [HREG_W-1:0]   ev_set,
  input  logic [1:0]          cu_state,
  input  logic [3:0]          ru_state,
  output logic                cu_valid,
  input  logic                cu_ready,
  output logic [CU_OP_W-1:0]  cu_op,
  output logic [PTR_W-1:0]    cu_ptr,
  output logic                ru_valid,
  input  logic                ru_ready,
  output logic [RU_OP_W-1:0]  ru_op,
  output logic [PTR_W-1:0]    ru_ptr,
  output logic                irq
);
  localparam int PAD_W = PTR_W - HREG_W;

  haddr_e           sel;
  logic             wr_stat, wr_cmd, wr_ptr;
  logic             swi_pulse;
  logic             mask_q;
  logic [PTR_W-1:0] ptr_q;
  logic [HREG_W-1:0] set_vec, cause, stat_word, cmd_word;

  assign sel     = haddr_e'(host_addr);
  assign wr_stat = host_wr && (sel == A_STATUS);
  assign wr_cmd  = host_wr && (sel == A_CMD);
  assign wr_ptr  = host_wr && (sel == A_PTR);

  assign swi_pulse = wr_cmd && host_wdata[TRIG_BIT];
  assign set_vec   = (ev_set | (HREG_W'(swi_pulse) << SWI_BIT)) & CAUSE_BITS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= 1'b1;
      ptr_q  <= '0;
    end else begin
      if (wr_cmd) mask_q <= host_wdata[MASK_BIT];
      if (wr_ptr) ptr_q  <= host_wdata;
    end
  end

  hcs_cause #(.W(HREG_W), .KEEP(CAUSE_BITS)) u_cause (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .ack_wr  (wr_stat),
    .ack_vec (host_wdata[HREG_W-1:0]),
    .mask    (mask_q),
    .cause   (cause),
    .irq     (irq)
  );

  hcs_cmd_slot #(.OP_W(CU_OP_W), .PTR_W(PTR_W)) u_cu_slot (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (wr_cmd),
    .wop   (host_wdata[CU_LSB +: CU_OP_W]),
    .wptr  (ptr_q),
    .ready (cu_ready),
    .valid (cu_valid),
    .op    (cu_op),
    .ptr   (cu_ptr)
  );

  hcs_cmd_slot #(.OP_W(RU_OP_W), .PTR_W(PTR_W)) u_ru_slot (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (wr_cmd),
    .wop   (host_wdata[RU_LSB +: RU_OP_W]),
    .wptr  (ptr_q),
    .ready (ru_ready),
    .valid (ru_valid),
    .op    (ru_op),
    .ptr   (ru_ptr)
  );

  always_comb begin
    stat_word = cause;
    stat_word[CUST_LSB +: 2] = cu_state;
    stat_word[RUST_LSB +: 4] = ru_state;
    cmd_word = '0;
    cmd_word[CU_LSB +: CU_OP_W] = cu_op;
    cmd_word[RU_LSB +: RU_OP_W] = ru_op;
    cmd_word[MASK_BIT] = mask_q;
  end

  always_comb begin
    case (sel)
      A_STATUS: host_rdata = {{PAD_W{1'b0}}, stat_word};
      A_CMD:    host_rdata = {{PAD_W{1'b0}}, cmd_word};
      A_PTR:    host_rdata = ptr_q;
      default:  host_rdata = '0;
    endcase
  end

  // R3
  swi_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swi_pulse |=> cause[SWI_BIT]);
  // R4
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_q && cause != '0) |-> irq);
endmodule

// File: tb/host_cmd_stat_test.sv
module host_cmd_stat_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic [15:0] ev_set = '0;
  logic [1:0]  cu_state = '0;
  logic [3:0]  ru_state = '0;
  logic        cu_valid, ru_valid, irq;
  logic        cu_ready = 1'b0, ru_ready = 1'b0;
  logic [3:0]  cu_op;
  logic [2:0]  ru_op;
  logic [31:0] cu_ptr, ru_ptr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  host_cmd_stat uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .ev_set(ev_set),
    .cu_state(cu_state), .ru_state(ru_state), .cu_valid(cu_valid),
    .cu_ready(cu_ready), .cu_op(cu_op), .cu_ptr(cu_ptr), .ru_valid(ru_valid),
    .ru_ready(ru_ready), .ru_op(ru_op), .ru_ptr(ru_ptr), .irq(irq)
  );

  // {ev_set, status ack written same cycle, expected status}
  localparam logic [47:0] VEC [10] = '{
    {16'h8000, 16'h0000, 16'h8000},
    {16'h4000, 16'h0000, 16'hC000},
    {16'h0200, 16'h0000, 16'hC000},
    {16'h0000, 16'h8000, 16'h4000},
    {16'h4000, 16'h4000, 16'h4000},
    {16'h3D00, 16'h0000, 16'h7D00},
    {16'h0000, 16'h00FF, 16'h7D00},
    {16'h0000, 16'hFFFF, 16'h0000},
    {16'h0100, 16'h0000, 16'h0100},
    {16'h0000, 16'h0100, 16'h0000}
  };

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0; host_wdata = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    for (int n = 0; n < 5000; n++) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    rd(2'd0, d); check("R11 status after reset", d, 32'h0);
    rd(2'd1, d); check("R11 command after reset", d, 32'h0100);
    rd(2'd2, d); check("R11 pointer after reset", d, 32'h0);
    check("R11 valids after reset", {cu_valid, ru_valid}, 32'h0);
    check("R4 irq after reset", irq, 0);

    // R4 unmask, then walk cause table (R1 R2)
    wr(2'd1, 32'h0000);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      ev_set = VEC[i][47:32];
      host_wr = (VEC[i][31:16] != 0); host_addr = 2'd0; host_wdata = {16'h0, VEC[i][31:16]};
      @(negedge clk);
      ev_set = '0; host_wr = 1'b0; host_wdata = '0;
      rd(2'd0, d); check($sformatf("R1 R2 cause step %0d", i), d, {16'h0, VEC[i][15:0]});
      check($sformatf("R4 irq step %0d", i), irq, (VEC[i][15:0] != 0));
    end

    // R3 software trigger
    wr(2'd1, 32'h0200);
    rd(2'd0, d); check("R3 swi cause", d, 32'h0400);
    rd(2'd1, d); check("R3 trigger bit reads 0", d, 32'h0000);
    check("R4 irq on swi", irq, 1);
    wr(2'd0, 32'h0400);

    // R4 mask
    wr(2'd1, 32'h0100);
    @(negedge clk); ev_set = 16'h0800; @(negedge clk); ev_set = '0;
    rd(2'd0, d); check("R1 mgmt cause", d, 32'h0800);
    check("R4 irq masked", irq, 0);
    wr(2'd1, 32'h0000);
    check("R4 irq unmasked", irq, 1);
    wr(2'd0, 32'h0800);
    check("R2 irq after ack", irq, 0);

    // R5 state reflection
    cu_state = 2'd2; ru_state = 4'b1100;
    rd(2'd0, d); check("R5 unit states", d, 32'h00B0);
    cu_state = 2'd0; ru_state = 4'd0;

    // R6 R8 R10 R9 command unit
    wr(2'd2, 32'h12345678);
    rd(2'd2, d); check("R11 pointer readback", d, 32'h12345678);
    wr(2'd1, 32'h0010);
    check("R6 cu request", {cu_valid, cu_op}, {1'b1, 4'd1});
    check("R6 cu pointer", cu_ptr, 32'h12345678);
    check("R7 no ru request", ru_valid, 0);
    wr(2'd2, 32'hAAAA0000);
    wr(2'd1, 32'h0050);
    rd(2'd1, d); check("R10 busy write ignored", d, 32'h0010);
    check("R8 pointer held", cu_ptr, 32'h12345678);
    check("R8 valid held", {cu_valid, cu_op}, {1'b1, 4'd1});
    @(negedge clk); cu_ready = 1'b1; @(negedge clk); cu_ready = 1'b0;
    check("R9 cu valid dropped", cu_valid, 0);
    rd(2'd1, d); check("R9 cu field cleared", d, 32'h0000);

    // R7 R10 both units
    wr(2'd2, 32'h0000BEEF);
    wr(2'd1, 32'h0024);
    check("R6 R7 both ops", {cu_valid, cu_op, ru_valid, ru_op}, {1'b1, 4'd2, 1'b1, 3'd4});
    check("R7 ru pointer", ru_ptr, 32'h0000BEEF);
    @(negedge clk); ru_ready = 1'b1; @(negedge clk); ru_ready = 1'b0;
    rd(2'd1, d); check("R9 ru cleared cu waits", d, 32'h0020);
    wr(2'd2, 32'h00C0FFEE);
    wr(2'd1, 32'h0046);
    rd(2'd1, d); check("R10 idle field taken busy ignored", d, 32'h0026);
    check("R10 ru new pointer", ru_ptr, 32'h00C0FFEE);
    check("R8 cu pointer kept", cu_ptr, 32'h0000BEEF);
    @(negedge clk); cu_ready = 1'b1; ru_ready = 1'b1;
    @(negedge clk); cu_ready = 1'b0; ru_ready = 1'b0;
    rd(2'd1, d); check("R9 both cleared", d, 32'h0000);

    // R7 zero field makes no request
    wr(2'd1, 32'h0000);
    check("R7 ru no-op", ru_valid, 0);
    rd(2'd3, d); check("R11 unused address", d, 32'h0);

    finish_run();
  end
endmodule